// File: doc/BRIEF.md
# 1-Wire Slave Slot Engine

This block is the bit-level front end of a 1-Wire slave. It watches the raw open-drain bus level and owns a single active-high pull-down request. It recognises a master reset from the length of a low period and answers it with a presence pulse. It times every slot that the master opens with a falling edge. In a slot it either samples the bus to receive one bit, or it transmits one bit. A transmitted zero is produced by pulling the line low from the very edge the master made.

Every duration is counted in ticks of a prescaled timer. The tick length and all slot times are parameters. The timer restarts on each event that begins a new interval.

Toward the protocol layer the block offers three things:
- a strobe that marks the end of a reset and presence sequence;
- a received-bit strobe with its value;
- a transmit request made of a bit and a valid flag. The valid flag is sampled at the falling edge, and a strobe acknowledges it.

Top module: `onewire_slot_phy`

## Requirements
- R1: During and after synchronous reset, `pull_low`, `rx_stb`, `tx_take` and `reset_done` are all 0, with the bus idle high.
- R2: A bus low of at least `RST_MIN_T` ticks ended by a rising edge is a reset. `PRES_WAIT_T` ticks after that rise, `pull_low` goes to 1 for exactly `PRES_LEN_T` ticks. `reset_done` pulses for one cycle in the cycle `pull_low` returns to 0.
- R3: A bus low shorter than `RST_MIN_T` ticks produces neither a presence pulse nor `reset_done`.
- R4: A falling edge seen while `tx_valid` = 0 opens a receive slot. `SAMPLE_T` ticks later, `rx_stb` pulses for one cycle with `rx_bit` = 1 if the bus is high and 0 if it is low.
- R5: A falling edge seen while `tx_valid` = 1 and `tx_bit` = 0 raises `pull_low` in the same cycle that the edge is detected. `pull_low` stays high for `DRIVE_T` ticks plus that detection cycle.
- R6: A falling edge seen while `tx_valid` = 1 and `tx_bit` = 1 never raises `pull_low` and produces no `rx_stb`.
- R7: `tx_take` pulses for one cycle on each falling edge that opens a transmit slot, and only then.
- R8: The bus passes through a two-flop synchroniser. The bus is first sampled low on some clock edge; the falling-edge response (`tx_take` and a zero's pull-down) appears in the cycle after the next edge.
- R9: A low period that begins as a slot and lasts into the reset window aborts that slot and leads into the presence sequence of R2.
- R10: Falling edges during the presence wait or the presence pulse open no slot: no `tx_take` and no `rx_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Raw bus level, 1 = high |
| pull_low | output | 1 | 1 = drive the bus low |
| tx_valid | input | 1 | 1 = next slot transmits `tx_bit` |
| tx_bit | input | 1 | Bit to transmit; 0 pulls the line low |
| tx_take | output | 1 | One-cycle strobe: transmit request consumed |
| rx_stb | output | 1 | One-cycle strobe: received bit valid |
| rx_bit | output | 1 | Received bit value |
| reset_done | output | 1 | One-cycle strobe at end of presence pulse |

## Verification
A state machine stuck in the wrong state shows up at the ports within one slot. It can do this in three ways:
- a missing or extra `rx_stb` or `tx_take` at the next falling edge;
- a pull-down run of the wrong length;
- a presence pulse after a short low, or none after a long one.

Timer or prescaler faults move the receive strobe, the drive release or the presence start by whole ticks. The bench therefore measures each of these against the bus edge it drove, to the exact cycle. An error in the synchroniser or the edge detector shifts the first response away from the second cycle after the bus falls.

// File: rtl/onewire_slot_pkg.sv
package onewire_slot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_TX,
        ST_LOWWAIT,
        ST_ARMED,
        ST_PWAIT,
        ST_PRES
    } slot_state_e;

    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } line_evt_t;

    function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // True on the tick that completes n ticks since the last timer clear.
    function automatic logic tick_hit(logic tick, int unsigned cnt, int unsigned n);
        return tick && (cnt == n - 1);
    endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync
    import onewire_slot_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_in,
    output line_evt_t evt
);
    logic [STAGES-1:0] sh;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= bus_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], bus_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= sh[STAGES-1];
    end

    always_comb begin
        evt.level = sh[STAGES-1];
        evt.fall  = prev & ~sh[STAGES-1];
        evt.rise  = ~prev & sh[STAGES-1];
    end
endmodule

// File: rtl/ow_tick_timer.sv
module ow_tick_timer #(
    parameter int unsigned TICK_DIV = 64,
    parameter int unsigned CNT_MAX  = 51,
    parameter int unsigned PRE_W    = 6,
    parameter int unsigned CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic             tick,
    output logic [CNT_W-1:0] tcnt
);
    logic [PRE_W-1:0] pre;

    assign tick = (pre == PRE_W'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre  <= '0;
            tcnt <= '0;
        end else if (tick) begin
            pre <= '0;
            if (tcnt != CNT_W'(CNT_MAX)) tcnt <= tcnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
    import onewire_slot_pkg::*;
#(
    parameter int unsigned RST_MIN_T   = 51,
    parameter int unsigned PRES_WAIT_T = 4,
    parameter int unsigned PRES_LEN_T  = 20,
    parameter int unsigned SAMPLE_T    = 3,
    parameter int unsigned DRIVE_T     = 3,
    parameter int unsigned CNT_W       = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  line_evt_t        evt,
    input  logic             tick,
    input  logic [CNT_W-1:0] tcnt,
    input  logic             tx_valid,
    input  logic             tx_bit,
    output logic             timer_clr,
    output slot_state_e      state,
    output logic             pull_low,
    output logic             tx_take,
    output logic             rx_stb,
    output logic             rx_bit,
    output logic             reset_done
);
    logic        drive_q;
    int unsigned cnt32;

    assign cnt32 = 32'(tcnt);

    // Zero bits are driven combinationally from the detected edge.
    assign tx_take  = (state == ST_IDLE) && evt.fall && tx_valid;
    assign pull_low = drive_q | (tx_take & ~tx_bit);

    always_comb begin
        timer_clr = 1'b0;
        unique case (state)
            ST_IDLE:  timer_clr = evt.fall;
            ST_ARMED: timer_clr = evt.rise;
            ST_PWAIT: timer_clr = tick_hit(tick, cnt32, PRES_WAIT_T);
            default:  timer_clr = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            drive_q    <= 1'b0;
            rx_stb     <= 1'b0;
            rx_bit     <= 1'b0;
            reset_done <= 1'b0;
        end else begin
            rx_stb     <= 1'b0;
            reset_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (evt.fall) begin
                        if (tx_valid) begin
                            state   <= ST_TX;
                            drive_q <= ~tx_bit;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (tick_hit(tick, cnt32, SAMPLE_T)) begin
                        rx_stb <= 1'b1;
                        rx_bit <= evt.level;
                        state  <= ST_LOWWAIT;
                    end
                end
                ST_TX: begin
                    if (tick_hit(tick, cnt32, DRIVE_T)) begin
                        drive_q <= 1'b0;
                        state   <= ST_LOWWAIT;
                    end
                end
                ST_LOWWAIT: begin
                    if (evt.level)                               state <= ST_IDLE;
                    else if (tick_hit(tick, cnt32, RST_MIN_T))   state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (evt.rise) state <= ST_PWAIT;
                end
                ST_PWAIT: begin
                    if (tick_hit(tick, cnt32, PRES_WAIT_T)) begin
                        drive_q <= 1'b1;
                        state   <= ST_PRES;
                    end
                end
                ST_PRES: begin
                    if (tick_hit(tick, cnt32, PRES_LEN_T)) begin
                        drive_q    <= 1'b0;
                        reset_done <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/onewire_slot_phy.sv
module onewire_slot_phy
    import onewire_slot_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 64,
    parameter int unsigned RST_MIN_T   = 51,
    parameter int unsigned PRES_WAIT_T = 4,
    parameter int unsigned PRES_LEN_T  = 20,
    parameter int unsigned SAMPLE_T    = 3,
    parameter int unsigned DRIVE_T     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_in,
    output logic pull_low,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic tx_take,
    output logic rx_stb,
    output logic rx_bit,
    output logic reset_done
);
    localparam int unsigned CNT_MAX = max_of3(RST_MIN_T, max_of3(PRES_WAIT_T, PRES_LEN_T, 1),
                                              max_of3(SAMPLE_T, DRIVE_T, 1));
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam int unsigned PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    line_evt_t        evt;
    logic             tick;
    logic             timer_clr;
    logic [CNT_W-1:0] tcnt;
    slot_state_e      state;

    ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .bus_in (bus_in),
        .evt    (evt)
    );

    ow_tick_timer #(
        .TICK_DIV (TICK_DIV),
        .CNT_MAX  (CNT_MAX),
        .PRE_W    (PRE_W),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (timer_clr),
        .tick (tick),
        .tcnt (tcnt)
    );

    ow_slot_fsm #(
        .RST_MIN_T   (RST_MIN_T),
        .PRES_WAIT_T (PRES_WAIT_T),
        .PRES_LEN_T  (PRES_LEN_T),
        .SAMPLE_T    (SAMPLE_T),
        .DRIVE_T     (DRIVE_T),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .tick       (tick),
        .tcnt       (tcnt),
        .tx_valid   (tx_valid),
        .tx_bit     (tx_bit),
        .timer_clr  (timer_clr),
        .state      (state),
        .pull_low   (pull_low),
        .tx_take    (tx_take),
        .rx_stb     (rx_stb),
        .rx_bit     (rx_bit),
        .reset_done (reset_done)
    );
endmodule

// File: rtl/onewire_slot_phy_checker.sv
module onewire_slot_phy_checker
    import onewire_slot_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        pull_low,
    input logic        tx_take,
    input logic        tx_bit,
    input logic        rx_stb,
    input logic        reset_done,
    input slot_state_e state
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!pull_low && !rx_stb && !reset_done && !tx_take));

    a_r2_done_ends_presence: assert property (@(posedge clk) disable iff (rst)
        reset_done |-> ($past(pull_low) && !pull_low));

    a_r2_pull_source: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_low) |-> (tx_take || state == ST_PRES));

    a_r5_zero_held: assert property (@(posedge clk) disable iff (rst)
        (tx_take && !tx_bit) |=> pull_low);

    a_r6_one_released: assert property (@(posedge clk) disable iff (rst)
        (tx_take && tx_bit) |=> !pull_low);

    a_r4_rx_tx_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rx_stb && tx_take));

    a_r10_no_slot_in_presence: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWAIT || state == ST_PRES) |-> (!tx_take && !rx_stb));
endmodule

bind onewire_slot_phy onewire_slot_phy_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pull_low   (pull_low),
    .tx_take    (tx_take),
    .tx_bit     (tx_bit),
    .rx_stb     (rx_stb),
    .reset_done (reset_done),
    .state      (state)
);

// File: tb/onewire_slot_phy_test.sv
`timescale 1ns/1ps
module onewire_slot_phy_test;
    localparam int TD = 8;
    localparam int ST = 3;
    localparam int DT = 3;
    localparam int PW = 4;
    localparam int PL = 20;

    typedef struct packed {
        logic       tv;
        logic       tb;
        logic [7:0] low_t;
        logic       exp_rx;
        logic       exp_bit;
        logic       exp_drive;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b0, 8'd6, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd1, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 8'd1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'd2, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 8'd6, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b0, 8'd4, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, m_low = 1'b0, tx_valid = 1'b0, tx_bit = 1'b1;
    logic bus_in, pull_low, tx_take, rx_stb, rx_bit, reset_done;
    assign bus_in = ~(m_low | pull_low);

    onewire_slot_phy #(.TICK_DIV(TD)) uut (
        .clk(clk), .rst(rst), .bus_in(bus_in), .pull_low(pull_low),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_take(tx_take),
        .rx_stb(rx_stb), .rx_bit(rx_bit), .reset_done(reset_done)
    );

    int cyc = 0;
    int n_rx = 0, rx_cyc = 0, n_take = 0, take_cyc = 0, n_done = 0, done_cyc = 0;
    int n_runs = 0, run_start = 0, run_len = 0;
    logic last_rx_bit = 1'b0, pull_prev = 1'b0;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always @(posedge clk) begin
        #1;
        cyc++;
        if (rx_stb) begin n_rx++; rx_cyc = cyc; last_rx_bit = rx_bit; end
        if (tx_take) begin n_take++; take_cyc = cyc; end
        if (reset_done) begin n_done++; done_cyc = cyc; end
        if (pull_low && !pull_prev) run_start = cyc;
        if (!pull_low && pull_prev) begin run_len = cyc - run_start; n_runs++; end
        pull_prev = pull_low;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TD) @(negedge clk);
    endtask

    task automatic do_reset(input int low_t, output int r);
        @(negedge clk);
        m_low = 1'b1;
        wait_ticks(low_t);
        m_low = 1'b0;
        r = cyc;
        wait_ticks(40);
    endtask

    initial begin
        vec_t v;
        int d, r, rx0, tk0, dn0, rn0;
        repeat (4) @(negedge clk);
        tx_valid = 1'b1;
        @(negedge clk);
        // R1: quiet during and after reset
        check("R1 pull_low", int'(pull_low), 0);
        check("R1 tx_take", int'(tx_take), 0);
        rst = 1'b0;
        tx_valid = 1'b0;
        wait_ticks(2);
        check("R1 strobes", n_rx + n_take + n_done + n_runs, 0);

        // R2: power-on reset and presence
        do_reset(60, r);
        check("R2 presence count", n_runs, 1);
        check("R2 presence start", run_start - r, PW * TD + 3);
        check("R2 presence length", run_len, PL * TD);
        check("R2 reset_done count", n_done, 1);
        check("R2 reset_done cycle", done_cyc - r, (PW + PL) * TD + 3);

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            rx0 = n_rx; tk0 = n_take; dn0 = n_done; rn0 = n_runs;
            @(negedge clk);
            tx_valid = v.tv; tx_bit = v.tb; m_low = 1'b1; d = cyc;
            wait_ticks(int'(v.low_t));
            m_low = 1'b0;
            wait_ticks(12);
            tx_valid = 1'b0; tx_bit = 1'b1;
            check("R4 rx count", n_rx - rx0, int'(v.exp_rx));
            if (v.exp_rx) begin
                check("R4 rx bit", int'(last_rx_bit), int'(v.exp_bit));
                check("R4 rx cycle", rx_cyc - d, ST * TD + 3);
            end
            check("R7 take count", n_take - tk0, int'(v.tv));
            if (v.tv) check("R8 take latency", take_cyc - d, 2);
            check("R5 R6 drive count", n_runs - rn0, int'(v.exp_drive));
            if (v.exp_drive) begin
                check("R8 drive latency", run_start - d, 2);
                check("R5 drive length", run_len, DT * TD + 1);
            end
            check("R3 no reset from slot", n_done - dn0, 0);
        end

        // R3: short low is not a reset
        dn0 = n_done; rn0 = n_runs;
        do_reset(40, r);
        check("R3 no presence", n_runs - rn0, 0);
        check("R3 no reset_done", n_done - dn0, 0);

        // R9: zero slot stretched into a reset
        tk0 = n_take; dn0 = n_done; rn0 = n_runs;
        tx_valid = 1'b1; tx_bit = 1'b0;
        do_reset(60, r);
        tx_valid = 1'b0; tx_bit = 1'b1;
        check("R9 slot taken", n_take - tk0, 1);
        check("R9 drive then presence", n_runs - rn0, 2);
        check("R9 presence length", run_len, PL * TD);
        check("R9 reset_done", n_done - dn0, 1);
        check("R9 presence start", run_start - r, PW * TD + 3);

        // R10: edges inside the presence wait are ignored
        @(negedge clk);
        m_low = 1'b1;
        wait_ticks(60);
        m_low = 1'b0;
        r = cyc;
        tk0 = n_take; rx0 = n_rx; dn0 = n_done;
        wait_ticks(1);
        tx_valid = 1'b1; tx_bit = 1'b0; m_low = 1'b1;
        wait_ticks(1);
        m_low = 1'b0;
        wait_ticks(38);
        tx_valid = 1'b0; tx_bit = 1'b1;
        check("R10 no take", n_take - tk0, 0);
        check("R10 no rx", n_rx - rx0, 0);
        check("R10 presence start", run_start - r, PW * TD + 3);
        check("R10 reset_done", n_done - dn0, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule